// File: doc/BRIEF.md
# Fixed-Point Rounding Increment Decider

This combinational unit tells a fixed-point datapath whether a value that is about to be shifted right must be bumped up by one. It is shared by the averaging, scaling-shift and narrowing-clip paths. The unit does not shift the value and does not add the increment. It only makes the decision. It looks at three things: the bit that will become the new least-significant bit, the most-significant bit that will be thrown away (the half bit), and the OR of every discarded bit below the half bit.

The caller supplies a 64-bit operand, a right-shift distance and a 2-bit rounding mode. Within the same cycle, the unit returns one increment bit. Shift distances of zero and shift distances above the operand width are treated as degenerate. A shift equal to the operand width discards the whole operand, and the retained bit is then taken as zero.

Top module: `round_incr_decider`

## Requirements
- R1: When the shift distance is 0, the increment is 0 for every operand and mode.
- R2: When the shift distance is greater than 64 (65 to 127), the increment is 0 for every operand and mode.
- R3: With mode code 0 (round to nearest, ties up) and a shift s from 1 to 64, the increment equals operand bit s-1.
- R4: With mode code 1 (round to nearest, ties to even) and a shift s from 2 to 63, the increment is bit s-1 AND (bit s OR any of bits s-2..0 set).
- R5: With mode code 1 and a shift of exactly 1, there is no lower discarded bit, and the increment is bit 0 AND bit 1.
- R6: With mode code 2 (truncate toward minus infinity), the increment is always 0.
- R7: With mode code 3 (round to odd, or jam) and a shift s from 1 to 63, the increment is 1 exactly when bit s is 0 and at least one of bits s-1..0 is 1.
- R8: With a shift of exactly 64, all 64 operand bits count as discarded and the retained bit counts as 0. Mode 0 then gives bit 63, mode 1 gives bit 63 AND any of bits 62..0, and mode 3 gives 1 for any nonzero operand.
- R9: The increment depends only on the present inputs. It settles in the same cycle the inputs change, and it holds steady across clock edges while the inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 64 | Value that is about to be shifted right |
| shamt | input | 7 | Right-shift distance, 0 to 127 |
| rnd_mode | input | 2 | Rounding mode code: 0 nearest-up, 1 nearest-even, 2 truncate, 3 round-to-odd |
| incr | output | 1 | 1 when the shifted result must be incremented |

## Verification
A hand-built table sets the three decision bits one at a time. It places the half bit with and without lower sticky bits, with an even and an odd retained bit, and with an empty discard field. This separates the tie rule of nearest-even from nearest-up, and the jam rule of round-to-odd from a simple sticky test. A full sweep then covers every shift from 0 to 70 in all four modes. It uses all-zero, all-one, single-bit, alternating and pseudo-random operands, and checks them against a loop-based model. This exposes off-by-one errors in the mask boundaries and mistakes at the degenerate shift distances of 0, 64 and above 64.

// File: rtl/round_pkg.sv
package round_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_TRUNC     = 2'd2,
    RM_ODD       = 2'd3
  } rnd_mode_e;

endpackage

// File: rtl/round_shift_masks.sv
// Turns a shift distance into three bit-select masks over the operand:
// the bits strictly below the half bit, the half bit, and the retained bit.
module round_shift_masks #(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 7
) (
  input  logic [SHIFT_W-1:0] shamt,
  output logic [DATA_W-1:0]  below_mask,
  output logic [DATA_W-1:0]  half_sel,
  output logic [DATA_W-1:0]  keep_sel
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // bit i lies below the half bit when i < shamt-1, i.e. i+1 < shamt
    assign below_mask[i] = ({1'b0, shamt} > (SHIFT_W+1)'(i + 1));
    assign half_sel[i]   = (shamt == SHIFT_W'(i + 1));
    assign keep_sel[i]   = (shamt == SHIFT_W'(i));
  end

endmodule

// File: rtl/round_tap_reduce.sv
// AND-masks the operand and OR-reduces each field into one decision bit.
module round_tap_reduce #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] below_mask,
  input  logic [DATA_W-1:0] half_sel,
  input  logic [DATA_W-1:0] keep_sel,
  output logic              keep_bit,
  output logic              half_bit,
  output logic              low_sticky
);

  always_comb begin
    keep_bit   = |(operand & keep_sel);
    half_bit   = |(operand & half_sel);
    low_sticky = |(operand & below_mask);
  end

endmodule

// File: rtl/round_mode_decide.sv
// Applies the selected rounding rule to the three decision bits.
module round_mode_decide
  import round_pkg::*;
(
  input  logic       shift_ok,
  input  logic [1:0] rnd_mode,
  input  logic       keep_bit,
  input  logic       half_bit,
  input  logic       low_sticky,
  output logic       incr
);

  rnd_mode_e mode_q;
  logic      rule_out;

  always_comb begin
    mode_q = rnd_mode_e'(rnd_mode);
    unique case (mode_q)
      RM_NEAR_UP:   rule_out = half_bit;
      RM_NEAR_EVEN: rule_out = half_bit & (low_sticky | keep_bit);
      RM_ODD:       rule_out = ~keep_bit & (half_bit | low_sticky);
      default:      rule_out = 1'b0;
    endcase
    incr = shift_ok & rule_out;
  end

  always_comb begin
    if (mode_q == RM_TRUNC) begin
      AST_TRUNC_NEVER_BUMPS: assert (incr == 1'b0); // R6
    end
    if (incr && mode_q == RM_NEAR_EVEN) begin
      AST_EVEN_NEEDS_HALF: assert (half_bit); // R4
    end
  end

endmodule

// File: rtl/round_incr_decider.sv
// Top: rounding increment decision for a variable right shift.
module round_incr_decider
  import round_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0]  operand,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic [1:0]         rnd_mode,
  output logic               incr
);

  localparam logic [SHIFT_W-1:0] MAX_SHIFT = SHIFT_W'(DATA_W);

  logic [DATA_W-1:0] below_mask;
  logic [DATA_W-1:0] half_sel;
  logic [DATA_W-1:0] keep_sel;
  logic              keep_bit;
  logic              half_bit;
  logic              low_sticky;
  logic              shift_ok;

  assign shift_ok = (shamt != '0) && (shamt <= MAX_SHIFT);

  round_shift_masks #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_masks (
    .shamt      (shamt),
    .below_mask (below_mask),
    .half_sel   (half_sel),
    .keep_sel   (keep_sel)
  );

  round_tap_reduce #(.DATA_W(DATA_W)) u_taps (
    .operand    (operand),
    .below_mask (below_mask),
    .half_sel   (half_sel),
    .keep_sel   (keep_sel),
    .keep_bit   (keep_bit),
    .half_bit   (half_bit),
    .low_sticky (low_sticky)
  );

  round_mode_decide u_decide (
    .shift_ok   (shift_ok),
    .rnd_mode   (rnd_mode),
    .keep_bit   (keep_bit),
    .half_bit   (half_bit),
    .low_sticky (low_sticky),
    .incr       (incr)
  );

  // Port-level cross checks using direct indexing, independent of the masks
  always_comb begin
    automatic int s = int'(shamt);
    if (s == 0) begin
      AST_ZERO_SHIFT_QUIET: assert (incr == 1'b0); // R1
    end
    if (s > DATA_W) begin
      AST_OVER_SHIFT_QUIET: assert (incr == 1'b0); // R2
    end
    if (s >= 1 && s <= DATA_W && rnd_mode == 2'd0) begin
      AST_NEAR_UP_HALF: assert (incr == operand[s-1]); // R3
    end
    if (s >= 1 && s < DATA_W && rnd_mode == 2'd3 && incr) begin
      AST_ODD_KEEP_EVEN: assert (operand[s] == 1'b0); // R7
    end
    if (s == DATA_W && rnd_mode == 2'd3) begin
      AST_FULL_SHIFT_JAM: assert (incr == (|operand)); // R8
    end
  end

endmodule

// File: tb/sim_round_incr_decider.sv
module sim_round_incr_decider;

  localparam int DATA_W  = 64;
  localparam int SHIFT_W = 7;

  typedef struct packed {
    logic [63:0] val;
    logic [6:0]  sh;
    logic [1:0]  md;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  // operand, shift, mode, expected increment, requirement number
  localparam vec_t TABLE [19] = '{
    '{64'h3, 7'd1, 2'd0, 1'b1, 4'd3},                   // R3 half bit set
    '{64'h2, 7'd1, 2'd0, 1'b0, 4'd3},                   // R3 half bit clear
    '{64'h1, 7'd1, 2'd1, 1'b0, 4'd5},                   // R5 tie, even keep
    '{64'h3, 7'd1, 2'd1, 1'b1, 4'd5},                   // R5 tie, odd keep
    '{64'h4, 7'd3, 2'd1, 1'b0, 4'd4},                   // R4 tie to even
    '{64'hC, 7'd3, 2'd1, 1'b1, 4'd4},                   // R4 tie, odd keep
    '{64'h5, 7'd3, 2'd1, 1'b1, 4'd4},                   // R4 above half
    '{64'h10, 7'd4, 2'd3, 1'b0, 4'd7},                  // R7 exact
    '{64'h01, 7'd4, 2'd3, 1'b1, 4'd7},                  // R7 jam into even
    '{64'h11, 7'd4, 2'd3, 1'b0, 4'd7},                  // R7 already odd
    '{64'hFFFF_FFFF_FFFF_FFFF, 7'd8, 2'd2, 1'b0, 4'd6}, // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 7'd0, 2'd0, 1'b0, 4'd1}, // R1
    '{64'hFFFF_FFFF_FFFF_FFFF, 7'd65, 2'd0, 1'b0, 4'd2},  // R2
    '{64'hFFFF_FFFF_FFFF_FFFF, 7'd127, 2'd3, 1'b0, 4'd2}, // R2
    '{64'h8000_0000_0000_0000, 7'd64, 2'd0, 1'b1, 4'd8},  // R8
    '{64'h8000_0000_0000_0000, 7'd64, 2'd1, 1'b0, 4'd8},  // R8
    '{64'h8000_0000_0000_0001, 7'd64, 2'd1, 1'b1, 4'd8},  // R8
    '{64'h1, 7'd64, 2'd3, 1'b1, 4'd8},                  // R8
    '{64'h0, 7'd64, 2'd3, 1'b0, 4'd8}                   // R8
  };

  logic              clk;
  logic              rst_n;
  logic [DATA_W-1:0] operand;
  logic [SHIFT_W-1:0] shamt;
  logic [1:0]        rnd_mode;
  logic              incr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  round_incr_decider u0 (
    .operand  (operand),
    .shamt    (shamt),
    .rnd_mode (rnd_mode),
    .incr     (incr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic model(logic [63:0] v, int s, int m);
    logic half, keep, low;
    if (s == 0 || s > 64) return 1'b0;
    half = v[s-1];
    keep = (s < 64) ? v[s] : 1'b0;
    low  = 1'b0;
    for (int i = 0; i < s - 1; i++) low = low | v[i];
    case (m)
      0:       return half;
      1:       return half & (low | keep);
      3:       return ~keep & (half | low);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic got, logic want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: op=%h sh=%0d mode=%0d actual=%b expected=%b",
               tag, operand, shamt, rnd_mode, got, want);
    end
  endtask

  task automatic apply(logic [63:0] v, int s, int m);
    @(negedge clk);
    operand  = v;
    shamt    = SHIFT_W'(s);
    rnd_mode = 2'(m);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [63:0] lfsr;
    logic [63:0] pats [8];
    rst_n    = 1'b0;
    operand  = '0;
    shamt    = '0;
    rnd_mode = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset idle", incr, 1'b0);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < 19; k++) begin
      apply(TABLE[k].val, int'(TABLE[k].sh), int'(TABLE[k].md));
      check($sformatf("R%0d table[%0d]", TABLE[k].req, k), incr, TABLE[k].exp);
    end

    // sweep all shifts and modes; R1 R2 R3 R4 R5 R6 R7 R8 against the model
    lfsr = 64'hACE1_0F0F_1234_9876;
    for (int s = 0; s <= 70; s++) begin
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = 64'h5555_5555_5555_5555;
      pats[3] = 64'hAAAA_AAAA_AAAA_AAAA;
      pats[4] = (s >= 1 && s <= 64) ? (64'h1 << (s - 1)) : 64'h1;
      pats[5] = (s < 64) ? (64'h1 << s) | 64'h1 : 64'h8000_0000_0000_0000;
      for (int p = 6; p < 8; p++) begin
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        pats[p] = lfsr;
      end
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 8; p++) begin
          apply(pats[p], s, m);
          check($sformatf("R3-sweep s%0d m%0d", s, m), incr, model(pats[p], s, m));
        end
      end
    end

    // R9: output follows inputs within the same cycle, stable across edges
    apply(64'h6, 3, 0);
    check("R9 settle high", incr, 1'b1);
    operand = 64'h2;
    #1;
    check("R9 same-cycle change", incr, 1'b0);
    operand = 64'h6;
    repeat (3) @(posedge clk);
    #2;
    check("R9 hold across edges", incr, 1'b1);

    // R6 truncation with every shift on an all-ones operand
    for (int s = 1; s <= 64; s += 9) begin
      apply('1, s, 2);
      check("R6 truncate", incr, 1'b0);
    end

    done = 1;
    finish_run();
  end

endmodule